// File: doc/BRIEF.md
# Motor ADC Conversion Channel Sequencer

This block drives one shared analog-to-digital converter through a scan of motor measurement channels. A small control register sets the scan's channel set. Phase channels V and W are converted in every scan. An enable bit adds phase U, which gives three-phase measurement. A second enable bit adds one of four auxiliary inputs, chosen by a two-bit select field.

A start strobe begins a scan. For each slot, the sequencer holds a convert request together with a channel code. It waits until the converter returns a done handshake with data, then writes that data into the result register for the channel and moves to the next slot. One clock after the last result is stored, the block raises a single-cycle completion pulse. Software or a downstream datapath reads results through an address-based read port.

Top module: `madc_scan_seq`

## Requirements
- R1: While a slot is active, conv_req_o stays high and conv_ch_o holds steady until conv_done_i is sampled high. At that edge conv_data_i is written into the result register of the active channel. A conv_done_i seen while no request is active changes no result.
- R2: Every scan converts V (code 1) and then W (code 2). With both enable bits clear, the scan is V then W and nothing else.
- R3: With the U enable set, the scan begins with U (code 0) and then continues with V and W.
- R4: With the auxiliary enable set, one auxiliary slot follows W. Its code is 4 plus the select field, so select 00, 01, 10 and 11 give codes 4, 5, 6 and 7 (AUX0 to AUX3).
- R5: After reset, both enable bits and the select field are 0, busy_o, conv_req_o and scan_done_o are low, and every result reads 0.
- R6: The channel set and the auxiliary select are captured at the edge that accepts start_i. That capture uses the register contents from before any write in the same cycle. Register writes made during a scan do not alter that scan.
- R7: A start_i sampled while busy_o is high is ignored. A start_i sampled in the cycle that scan_done_o is high is accepted, because busy_o is already low then.
- R8: scan_done_o is high for exactly one clock: the cycle after the edge that stores the last result. That result is readable in the same cycle.
- R9: A result register keeps its value through scans that do not convert its channel. Read address 3 (unused) returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the control register |
| cfg_u_en_i | input | 1 | Write data: add phase U to the scan |
| cfg_aux_en_i | input | 1 | Write data: add one auxiliary input |
| cfg_aux_sel_i | input | AUX_SEL_W | Write data: auxiliary input select |
| start_i | input | 1 | Scan start strobe |
| conv_req_o | output | 1 | Convert request to the converter |
| conv_ch_o | output | AUX_SEL_W+1 | Channel code of the active request |
| conv_done_i | input | 1 | Converter done handshake |
| conv_data_i | input | DATA_W | Conversion result |
| busy_o | output | 1 | Scan in progress |
| scan_done_o | output | 1 | Single-cycle scan completion pulse |
| rd_ch_i | input | AUX_SEL_W+1 | Result read address (channel code) |
| rd_data_o | output | DATA_W | Result register at rd_ch_i |

## Verification
Two events can land in the same cycle. The first is the completion pulse of one scan together with the acceptance of a new start. The bench provokes it by raising start_i in the very cycle it sees scan_done_o high. The second is a control-register write together with a start, or a write during a running scan. The bench provokes it by issuing writes on the start edge and in mid-scan.

A behavioural model keeps a queue of expected channel codes and a result array. On every clock it is compared with the request, channel code, busy, pulse and the swept read port. The model confirms three things: the new scan follows the old register contents, the pulse stays exactly one cycle wide, and the next scan's first request appears without a gap.

// File: rtl/madc_pkg.sv
package madc_pkg;

  typedef enum logic [2:0] {
    SL_IDLE = 3'd0,
    SL_U    = 3'd1,
    SL_V    = 3'd2,
    SL_W    = 3'd3,
    SL_AUX  = 3'd4
  } slot_e;

  typedef struct packed {
    logic u_en;
    logic aux_en;
  } scan_set_t;

  function automatic slot_e first_slot(scan_set_t s);
    return s.u_en ? SL_U : SL_V;
  endfunction

  function automatic slot_e next_slot(slot_e cur, scan_set_t s);
    case (cur)
      SL_U:    return SL_V;
      SL_V:    return SL_W;
      SL_W:    return s.aux_en ? SL_AUX : SL_IDLE;
      default: return SL_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/madc_cfg_reg.sv
module madc_cfg_reg
  import madc_pkg::*;
#(
  parameter int AUX_SEL_W = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic                 u_en_i,
  input  logic                 aux_en_i,
  input  logic [AUX_SEL_W-1:0] aux_sel_i,
  output scan_set_t            set_o,
  output logic [AUX_SEL_W-1:0] aux_sel_o
);

  scan_set_t            set_q;
  logic [AUX_SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q <= '0;
      sel_q <= '0;
    end else if (we_i) begin
      set_q.u_en   <= u_en_i;
      set_q.aux_en <= aux_en_i;
      sel_q        <= aux_sel_i;
    end
  end

  assign set_o     = set_q;
  assign aux_sel_o = sel_q;

endmodule

// File: rtl/madc_scan_ctrl.sv
module madc_scan_ctrl
  import madc_pkg::*;
#(
  parameter int AUX_SEL_W = 2,
  parameter int CH_W      = AUX_SEL_W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  scan_set_t            set_i,
  input  logic [AUX_SEL_W-1:0] aux_sel_i,
  input  logic                 conv_done_i,
  output logic                 conv_req_o,
  output logic [CH_W-1:0]      conv_ch_o,
  output logic                 store_o,
  output logic                 scan_done_o
);

  localparam int N_AUX = 1 << AUX_SEL_W;
  localparam logic [CH_W-1:0] CODE_U = CH_W'(0);
  localparam logic [CH_W-1:0] CODE_V = CH_W'(1);
  localparam logic [CH_W-1:0] CODE_W = CH_W'(2);
  localparam logic [CH_W-1:0] CODE_AUX0 = CH_W'(N_AUX);

  slot_e                slot_q;
  slot_e                slot_nx;
  scan_set_t            lat_set_q;
  logic [AUX_SEL_W-1:0] lat_sel_q;
  logic                 done_q;
  logic                 accept;
  logic                 step;
  logic                 last;

  assign accept  = (slot_q == SL_IDLE) && start_i;
  assign step    = (slot_q != SL_IDLE) && conv_done_i;
  assign slot_nx = next_slot(slot_q, lat_set_q);
  assign last    = step && (slot_nx == SL_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q    <= SL_IDLE;
      lat_set_q <= '0;
      lat_sel_q <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= last;
      if (accept) begin
        slot_q    <= first_slot(set_i);
        lat_set_q <= set_i;
        lat_sel_q <= aux_sel_i;
      end else if (step) begin
        slot_q <= slot_nx;
      end
    end
  end

  always_comb begin
    case (slot_q)
      SL_U:    conv_ch_o = CODE_U;
      SL_V:    conv_ch_o = CODE_V;
      SL_W:    conv_ch_o = CODE_W;
      SL_AUX:  conv_ch_o = CODE_AUX0 | CH_W'(lat_sel_q);
      default: conv_ch_o = '0;
    endcase
  end

  assign conv_req_o  = (slot_q != SL_IDLE);
  assign store_o     = step;
  assign scan_done_o = done_q;

endmodule

// File: rtl/madc_result_bank.sv
module madc_result_bank #(
  parameter int DATA_W    = 12,
  parameter int AUX_SEL_W = 2,
  parameter int CH_W      = AUX_SEL_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CH_W-1:0]   wr_ch_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [CH_W-1:0]   rd_ch_i,
  output logic [DATA_W-1:0] rd_data_o
);

  localparam int N_AUX  = 1 << AUX_SEL_W;
  localparam int N_CODE = 1 << CH_W;
  localparam int N_PH   = 3;

  logic [DATA_W-1:0] bank [N_CODE];

  for (genvar c = 0; c < N_CODE; c++) begin : g_slot
    if (c < N_PH || c >= N_AUX) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                  q <= '0;
        else if (wr_en_i && wr_ch_i == CH_W'(c))      q <= wr_data_i;
      end
      assign bank[c] = q;
    end else begin : g_gap
      assign bank[c] = '0;
    end
  end

  assign rd_data_o = bank[rd_ch_i];

endmodule

// File: rtl/madc_scan_seq.sv
module madc_scan_seq
  import madc_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int AUX_SEL_W = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic                 cfg_u_en_i,
  input  logic                 cfg_aux_en_i,
  input  logic [AUX_SEL_W-1:0] cfg_aux_sel_i,
  input  logic                 start_i,
  output logic                 conv_req_o,
  output logic [AUX_SEL_W:0]   conv_ch_o,
  input  logic                 conv_done_i,
  input  logic [DATA_W-1:0]    conv_data_i,
  output logic                 busy_o,
  output logic                 scan_done_o,
  input  logic [AUX_SEL_W:0]   rd_ch_i,
  output logic [DATA_W-1:0]    rd_data_o
);

  localparam int CH_W  = AUX_SEL_W + 1;
  localparam int N_AUX = 1 << AUX_SEL_W;

  scan_set_t            set_w;
  logic [AUX_SEL_W-1:0] sel_w;
  logic                 store_w;

  madc_cfg_reg #(.AUX_SEL_W(AUX_SEL_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .u_en_i    (cfg_u_en_i),
    .aux_en_i  (cfg_aux_en_i),
    .aux_sel_i (cfg_aux_sel_i),
    .set_o     (set_w),
    .aux_sel_o (sel_w)
  );

  madc_scan_ctrl #(.AUX_SEL_W(AUX_SEL_W), .CH_W(CH_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .set_i       (set_w),
    .aux_sel_i   (sel_w),
    .conv_done_i (conv_done_i),
    .conv_req_o  (conv_req_o),
    .conv_ch_o   (conv_ch_o),
    .store_o     (store_w),
    .scan_done_o (scan_done_o)
  );

  madc_result_bank #(.DATA_W(DATA_W), .AUX_SEL_W(AUX_SEL_W), .CH_W(CH_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (store_w),
    .wr_ch_i   (conv_ch_o),
    .wr_data_i (conv_data_i),
    .rd_ch_i   (rd_ch_i),
    .rd_data_o (rd_data_o)
  );

  assign busy_o = conv_req_o;

endmodule

// File: rtl/madc_scan_seq_chk.sv
module madc_scan_seq_chk #(
  parameter int CH_W  = 3,
  parameter int N_AUX = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            conv_req_o,
  input logic            conv_done_i,
  input logic [CH_W-1:0] conv_ch_o,
  input logic            busy_o,
  input logic            scan_done_o
);

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o && !conv_done_i |=> conv_req_o && $stable(conv_ch_o)); // R1

  AST_V_THEN_W: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o && conv_done_i && conv_ch_o == CH_W'(1) |=> conv_req_o && conv_ch_o == CH_W'(2)); // R2

  AST_U_THEN_V: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o && conv_done_i && conv_ch_o == CH_W'(0) |=> conv_req_o && conv_ch_o == CH_W'(1)); // R3

  AST_AUX_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o && conv_done_i && conv_ch_o >= CH_W'(N_AUX) |=> !conv_req_o && scan_done_o); // R4

  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && !conv_done_i |=> busy_o && $stable(conv_ch_o)); // R7

  AST_DONE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_done_o |=> !scan_done_o); // R8

  AST_DONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_done_o |-> !busy_o && $past(conv_req_o && conv_done_i)); // R8

endmodule

bind madc_scan_seq madc_scan_seq_chk #(.CH_W(CH_W), .N_AUX(N_AUX)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .conv_req_o  (conv_req_o),
  .conv_done_i (conv_done_i),
  .conv_ch_o   (conv_ch_o),
  .busy_o      (busy_o),
  .scan_done_o (scan_done_o)
);

// File: tb/sim_madc_scan_seq.sv
module sim_madc_scan_seq;
  localparam int CLK_T = 10;
  localparam int DW    = 12;
  localparam int SW    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_u = 1'b0, cfg_aux = 1'b0;
  logic [SW-1:0] cfg_sel = '0;
  logic start = 1'b0;
  logic conv_req;
  logic [SW:0] conv_ch;
  logic conv_done = 1'b0;
  logic [DW-1:0] conv_data = '0;
  logic busy, scan_done;
  logic [SW:0] rd_ch = '0;
  logic [DW-1:0] rd_data;

  int checks = 0, fails = 0;
  bit finished = 0;
  bit spur_req = 0;

  always #(CLK_T/2) clk = ~clk;

  madc_scan_seq #(.DATA_W(DW), .AUX_SEL_W(SW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_u_en_i(cfg_u),
    .cfg_aux_en_i(cfg_aux), .cfg_aux_sel_i(cfg_sel), .start_i(start),
    .conv_req_o(conv_req), .conv_ch_o(conv_ch), .conv_done_i(conv_done),
    .conv_data_i(conv_data), .busy_o(busy), .scan_done_o(scan_done),
    .rd_ch_i(rd_ch), .rd_data_o(rd_data)
  );

  // reference model
  bit m_u, m_aux, m_busy, m_fin;
  int m_sel;
  int q[$];
  int m_res[8];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_u = 0; m_aux = 0; m_sel = 0; m_busy = 0; m_fin = 0;
      q.delete();
      foreach (m_res[i]) m_res[i] = 0;
    end else begin
      bit fin;
      fin = 0;
      if (m_busy && conv_done) begin
        m_res[q[0]] = int'(conv_data);
        void'(q.pop_front());
        if (q.size() == 0) begin m_busy = 0; fin = 1; end
      end else if (!m_busy && start) begin
        if (m_u) q.push_back(0);
        q.push_back(1);
        q.push_back(2);
        if (m_aux) q.push_back(4 + m_sel);
        m_busy = 1;
      end
      m_fin = fin;
      if (cfg_we) begin m_u = cfg_u; m_aux = cfg_aux; m_sel = int'(cfg_sel); end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n && !finished) begin
      chk(int'(conv_req), int'(m_busy), "R1 conv_req");
      if (m_busy) chk(int'(conv_ch), q[0], "R2 R3 R4 R6 R7 conv_ch");
      chk(int'(busy), int'(m_busy), "R7 busy");
      chk(int'(scan_done), int'(m_fin), "R8 scan_done");
      chk(int'(rd_data), m_res[rd_ch], "R1 R9 rd_data");
    end
  end

  // converter stub and read sweep
  initial begin
    int wait_cnt = 0, pat = 1, cyc = 0;
    logic [DW-1:0] lfsr = 12'hA5C;
    forever begin
      @(negedge clk);
      rd_ch = 3'(cyc); cyc++;
      if (conv_done) conv_done = 1'b0;
      else if (spur_req) begin
        conv_done = 1'b1; conv_data = 12'hFFF; spur_req = 0;
      end else if (conv_req) begin
        if (wait_cnt == 0) begin
          conv_done = 1'b1; conv_data = lfsr;
          lfsr = {lfsr[10:0], lfsr[11] ^ lfsr[5] ^ lfsr[3] ^ lfsr[0]};
          wait_cnt = pat; pat = (pat + 1) % 4;
        end else wait_cnt--;
      end
    end
  end

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic wcfg(input bit u, input bit a, input int s);
    @(negedge clk);
    cfg_we = 1; cfg_u = u; cfg_aux = a; cfg_sel = SW'(s);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!scan_done && n < 200) begin @(negedge clk); n++; end
    chk(int'(scan_done), 1, "R8 scan reached completion");
  endtask

  task automatic run_scan(input bit u, input bit a, input int s);
    wcfg(u, a, s);
    pulse_start();
    wait_done();
  endtask

  initial begin
    #(CLK_T * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    finished = 1;
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #3;
    chk(int'(busy), 0, "R5 reset busy");
    chk(int'(conv_req), 0, "R5 reset conv_req");
    chk(int'(scan_done), 0, "R5 reset scan_done");
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #3;
      chk(int'(rd_data), 0, "R5 reset result");
    end
    // R5 R2: default V,W scan with reset configuration
    pulse_start(); wait_done();
    // R1: spurious done while idle
    @(negedge clk); spur_req = 1;
    repeat (10) @(negedge clk);
    // R2 R3 R4: set variants
    run_scan(0, 0, 2);
    run_scan(1, 0, 0);
    for (int s = 0; s < 4; s++) run_scan(0, 1, s);
    for (int s = 0; s < 4; s++) run_scan(1, 1, s);
    // R9: V,W only, aux and U results must hold
    run_scan(0, 0, 0);
    repeat (10) @(negedge clk);
    // R6: write in start cycle, and mid-scan
    wcfg(1, 1, 1);
    @(negedge clk); start = 1; cfg_we = 1; cfg_u = 0; cfg_aux = 0; cfg_sel = 2'd3;
    @(negedge clk); start = 0; cfg_we = 0;
    @(negedge clk); cfg_we = 1; cfg_u = 1; cfg_aux = 1; cfg_sel = 2'd2;
    @(negedge clk); cfg_we = 0;
    wait_done();
    // R7: start while busy ignored
    pulse_start();
    repeat (3) @(negedge clk); start = 1;
    repeat (4) @(negedge clk); start = 0;
    wait_done();
    // R7 R8: start in the completion cycle
    start = 1; @(negedge clk); start = 0;
    chk(int'(busy), 1, "R7 start in done cycle accepted");
    wait_done();
    start = 1; @(negedge clk); start = 0;
    wait_done();
    repeat (12) @(negedge clk);
    finished = 1;
    report();
    $finish;
  end

endmodule